// File: doc/BRIEF.md
# Pending Break Event Sampler

This block sits between a power-management controller and a processor whose error pin has two meanings. While the processor clock is running, the active-low pin reports a floating-point error. While the block holds the clock-stop output high, the same pin reports, active low, that an interrupt is pending. The block raises clock-stop when its stop request is present. On that same edge it captures the pin level, and it uses only that captured copy while the stop lasts. Once the processor acknowledges with a stop-grant strobe, a captured low level produces a single-cycle break event. The break event releases clock-stop so that the processor returns to full run.

When clock-stop falls, the processor needs time to give the pin back its error meaning. The block therefore blanks the pin for a fixed number of bus clocks. It forces the error output low during that window, and it holds off any new stop request until the window is over. The pin is sampled again before clock-stop can next rise. With the default of six blanked clocks at a 33 MHz bus clock, the wait falls between the required 180 ns and 240 ns. A break event raised this way sets no status of any kind.

Top module: `pbe_sampler`

## Requirements
- R1: While reset is held and in the first cycle after it, clk_stop and break_event are 0.
- R2: With clock-stop inactive and outside the blanking window, a high stop_req sampled at a clock edge makes clk_stop 1 from that edge on.
- R3: The pin level sampled at the edge where clk_stop rises is held for the whole stop phase, and later pin changes during the stop have no effect on break_event.
- R4: break_event is 1 for exactly one cycle, starting at the edge after a grant strobe is sampled during the stop phase, and only if the captured pin level was 0 (low = interrupt pending); with a captured 1 no break occurs.
- R5: At the edge that ends a break_event cycle, clk_stop returns to 0.
- R6: If stop_req is 0 at an edge while clk_stop is 1, clk_stop is 0 from that edge on.
- R7: fp_error equals the inverse of the pin (low pin = error) only outside the stop phase and outside the blanking window; otherwise fp_error is 0.
- R8: For BLANK_CLKS (default 6) cycles after clk_stop falls, the pin is blanked and stop_req is ignored, so clk_stop stays 0 for at least BLANK_CLKS+1 cycles.
- R9: A grant strobe while clk_stop is 0 produces no break_event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Request to stop the processor clock |
| cpu_pin_n | input | 1 | Multiplexed processor pin, active low |
| grant_stb | input | 1 | Stop-grant acknowledge strobe |
| break_event | output | 1 | One-cycle break indication, forces return to run |
| fp_error | output | 1 | Floating-point error, valid outside stop and blanking |
| clk_stop | output | 1 | Clock-stop request to the processor |

## Verification
A phase register that is out of step shows at the ports within one cycle. clk_stop stays up after a release or a break, or fp_error follows the pin while it should be blanked. A captured level that is not held shows up as break_event tracking late pin changes, in the cycle after the grant. A blanking counter that ends early or late moves the first cycle of valid fp_error, and the first edge where clk_stop can rise again, by the size of the error.

// File: rtl/pbe_pkg.sv
package pbe_pkg;
  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_WAIT  = 2'd1,
    PH_GRANT = 2'd2,
    PH_BLANK = 2'd3
  } pbe_phase_e;
endpackage

// File: rtl/pbe_blank_timer.sv
module pbe_blank_timer #(
  parameter int BLANK_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);
  localparam int CW = (BLANK_CLKS > 1) ? $clog2(BLANK_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BLANK_CLKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!active)           cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = cnt_q;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = active && (cnt_q == LAST);
endmodule

// File: rtl/pbe_pin_latch.sv
module pbe_pin_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic pin_n,
  output logic held_n
);
  logic held_d;

  always_comb held_d = capture ? pin_n : held_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_n <= 1'b1;
    else if (capture) held_n <= held_d;
  end
endmodule

// File: rtl/pbe_phase_fsm.sv
module pbe_phase_fsm
  import pbe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stop_req,
  input  logic       grant_stb,
  input  logic       held_n,
  input  logic       blank_done,
  output pbe_phase_e phase,
  output logic       capture
);
  pbe_phase_e ph_d;

  always_comb begin
    ph_d    = phase;
    capture = 1'b0;
    unique case (phase)
      PH_RUN: begin
        if (stop_req) begin
          ph_d    = PH_WAIT;
          capture = 1'b1;
        end
      end
      PH_WAIT: begin
        if (!stop_req)      ph_d = PH_BLANK;
        else if (grant_stb) ph_d = PH_GRANT;
      end
      PH_GRANT: begin
        if (!held_n || !stop_req) ph_d = PH_BLANK;
      end
      PH_BLANK: begin
        if (blank_done) ph_d = PH_RUN;
      end
      default: ph_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_RUN;
    else        phase <= ph_d;
  end
endmodule

// File: rtl/pbe_sampler.sv
module pbe_sampler
  import pbe_pkg::*;
#(
  parameter int BLANK_CLKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic cpu_pin_n,
  input  logic grant_stb,
  output logic break_event,
  output logic fp_error,
  output logic clk_stop
);
  pbe_phase_e phase;
  logic       capture;
  logic       held_n;
  logic       blank_done;
  logic       blank_on;

  assign blank_on = (phase == PH_BLANK);

  pbe_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .grant_stb  (grant_stb),
    .held_n     (held_n),
    .blank_done (blank_done),
    .phase      (phase),
    .capture    (capture)
  );

  pbe_pin_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (capture),
    .pin_n   (cpu_pin_n),
    .held_n  (held_n)
  );

  pbe_blank_timer #(.BLANK_CLKS(BLANK_CLKS)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (blank_on),
    .done   (blank_done)
  );

  assign clk_stop    = (phase == PH_WAIT) || (phase == PH_GRANT);
  assign break_event = (phase == PH_GRANT) && !held_n;
  assign fp_error    = (phase == PH_RUN) && !cpu_pin_n;
endmodule

// File: rtl/pbe_sampler_chk.sv
module pbe_sampler_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic break_event,
  input logic fp_error,
  input logic clk_stop,
  input logic blank_on,
  input logic held_n
);
  a_r4_break_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    break_event |-> clk_stop);
  a_r4_break_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    break_event |=> !break_event);
  a_r5_break_releases: assert property (@(posedge clk) disable iff (!rst_n)
    break_event |=> !clk_stop);
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && !stop_req) |=> !clk_stop);
  a_r7_quiet_stop: assert property (@(posedge clk) disable iff (!rst_n)
    clk_stop |-> !fp_error);
  a_r7_quiet_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank_on |-> !fp_error);
  a_r8_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    blank_on |=> !clk_stop);
  a_r3_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stop && $past(clk_stop)) |-> $stable(held_n));
endmodule

bind pbe_sampler pbe_sampler_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stop_req    (stop_req),
  .break_event (break_event),
  .fp_error    (fp_error),
  .clk_stop    (clk_stop),
  .blank_on    (blank_on),
  .held_n      (held_n)
);

// File: tb/test_pbe_sampler.sv
module test_pbe_sampler;
  localparam int BLANK_CLKS = 6;

  logic clk = 1'b0;
  logic rst_n, stop_req, cpu_pin_n, grant_stb;
  logic break_event, fp_error, clk_stop;
  int   n_chk = 0, n_fail = 0;
  bit   done_flag = 1'b0;

  int m_ph, m_cnt;
  bit m_lat;

  always #5 clk = ~clk;

  pbe_sampler #(.BLANK_CLKS(BLANK_CLKS)) i_pbe_sampler (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .cpu_pin_n(cpu_pin_n),
    .grant_stb(grant_stb), .break_event(break_event), .fp_error(fp_error),
    .clk_stop(clk_stop)
  );

  function automatic bit exp_stop();  return (m_ph == 1) || (m_ph == 2); endfunction
  function automatic bit exp_break(); return (m_ph == 2) && !m_lat;      endfunction
  function automatic bit exp_fp();    return (m_ph == 0) && !cpu_pin_n;  endfunction

  function automatic string phase_tag();
    case (m_ph)
      0: return "R7";
      1: return "R3";
      2: return "R4";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, string what, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    case (m_ph)
      0: if (stop_req) begin m_ph = 1; m_lat = cpu_pin_n; end
      1: if (!stop_req) begin m_ph = 3; m_cnt = 0; end
         else if (grant_stb) m_ph = 2;
      2: if (!m_lat || !stop_req) begin m_ph = 3; m_cnt = 0; end
      default: if (m_cnt == BLANK_CLKS - 1) m_ph = 0; else m_cnt++;
    endcase
  endtask

  // check outputs at the falling edge, then drive new inputs and advance
  task automatic cycle(bit s, bit p, bit g, string tag);
    @(negedge clk);
    chk(tag, "clk_stop", clk_stop, exp_stop());
    chk(tag, "break_event", break_event, exp_break());
    chk(tag, "fp_error", fp_error, exp_fp());
    stop_req = s; cpu_pin_n = p; grant_stb = g;
    #1;
    chk(tag, "fp_error_new_pin", fp_error, exp_fp());
    @(posedge clk);
    model_step();
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; stop_req = 1'b1; cpu_pin_n = 1'b1; grant_stb = 1'b1;
    m_ph = 0; m_cnt = 0; m_lat = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "clk_stop", clk_stop, 1'b0);
    chk("R1", "break_event", break_event, 1'b0);
    stop_req = 1'b0; grant_stb = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cycle(0, 1, 0, "R1");
    // R9: grant while running, pin low
    cycle(0, 0, 1, "R9");
    cycle(0, 0, 1, "R9");
    cycle(0, 1, 0, "R9");
    // R3: capture low, pin rises before grant, break still due (R4, R5)
    cycle(1, 0, 0, "R2");
    cycle(1, 1, 0, "R3");
    cycle(1, 1, 1, "R3");
    cycle(1, 1, 0, "R4");
    cycle(1, 1, 0, "R5");
    // R8: stop_req held through blanking
    for (int i = 0; i < BLANK_CLKS + 2; i++) cycle(1, 0, 0, "R8");
    // captured high: grant gives no break, release drops stop (R6)
    cycle(0, 1, 0, "R6");
    for (int i = 0; i < BLANK_CLKS + 1; i++) cycle(0, 1, 0, "R8");
    cycle(1, 1, 0, "R3");
    cycle(1, 0, 1, "R4");
    cycle(1, 0, 0, "R4");
    cycle(0, 0, 0, "R6");
    cycle(0, 0, 0, "R6");
    for (int i = 0; i < BLANK_CLKS + 1; i++) cycle(0, 0, 0, "R7");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      bit s, p, g;
      s = ($urandom % 4) != 0;
      p = $urandom % 2;
      g = ($urandom % 3) == 0;
      cycle(s, p, g, phase_tag());
    end
    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule